// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Function Unit

This block is the function unit of a small datapath. It takes two operand words, a four-bit operation select, a carry input and two serial fill bits, and produces one result word plus a carry output. Three sections work on the operands side by side, and an output multiplexer keeps one of them. The arithmetic section is a single adder. All of its operations come from the choice of its second input (the B operand, its complement, all zeros or all ones) combined with the carry input. The logic section computes four bitwise functions. The shift section moves operand A by one position in either direction.

The two high select bits choose the section. For arithmetic and logic, the two low select bits choose the variant inside the section. The carry output is the adder's carry out of the most significant bit. It is forced low whenever the adder's result is not the one selected. The unit is combinational. A parameter places a result register at its outputs, which gives the unit a defined one-clock latency when it sits in a pipeline or a testbench. The "states" of the unit are the four section choices: ARITH, LOGIC, SHR and SHL. Every input pattern moves the unit directly to the section named by the top select bits. There is no sequence among them.

Top module: `alsu_top`

## Requirements
- R1: With sel = 4'b0000, f = (a + b + cin) mod 2^W and cout is the carry out of that sum.
- R2: With sel = 4'b0001, f = (a + ~b + cin) mod 2^W and cout is the carry out of that sum. With cin = 1 this is a - b, and cout = 1 means no borrow.
- R3: With sel = 4'b0010, the adder adds zero, so f = a + cin: a transfer when cin = 0 and an increment when cin = 1. cout is 1 only when a is all ones and cin = 1.
- R4: With sel = 4'b0011, the adder adds all ones, so f = a - 1 + cin: a decrement when cin = 0 and a transfer when cin = 1. cout is 1 unless a is zero and cin = 0.
- R5: With sel[3:2] = 2'b01, sel[1:0] picks the logic function: 00 gives a AND b, 01 gives a OR b, 10 gives a XOR b, 11 gives NOT a. cin has no effect on f.
- R6: With sel[3:2] = 2'b10, f = {ser_right, a[W-1:1]}. sel[1:0], cin, b and ser_left have no effect.
- R7: With sel[3:2] = 2'b11, f = {a[W-2:0], ser_left}. sel[1:0], cin, b and ser_right have no effect.
- R8: cout is 0 whenever sel[3:2] is not 2'b00.
- R9: With OUT_REG = 1, f and cout show the result of the inputs present at the previous rising clock edge. While rst_n is low, f and cout are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Active-low asynchronous reset of the result register |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| sel | input | 4 | Operation select: [3:2] picks the section, [1:0] picks the variant |
| cin | input | 1 | Adder carry input |
| ser_right | input | 1 | Bit shifted into the MSB on a right shift |
| ser_left | input | 1 | Bit shifted into the LSB on a left shift |
| f | output | WIDTH | Result word |
| cout | output | 1 | Adder carry out; 0 for logic and shift operations |

## Verification
The bench builds the unit with WIDTH = 4 and OUT_REG = 1. At that width it can drive every combination of both operands, all sixteen select codes, the carry input and both serial fill bits. Each carry boundary, such as all-ones plus one or zero minus one, is therefore hit under every select code. Each "no effect" claim is also tested against every value of the ignored inputs. The registered variant additionally makes the one-clock latency and the reset value visible at the ports.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        U_ARITH = 2'b00,
        U_LOGIC = 2'b01,
        U_SHR   = 2'b10,
        U_SHL   = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        Y_B     = 2'b00,
        Y_NOTB  = 2'b01,
        Y_ZERO  = 2'b10,
        Y_ONES  = 2'b11
    } yin_e;

    typedef enum logic [1:0] {
        L_AND   = 2'b00,
        L_OR    = 2'b01,
        L_XOR   = 2'b10,
        L_NOTA  = 2'b11
    } lfn_e;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       ysel,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry
);
    localparam int EW = WIDTH + 1;

    yin_e             ymode;
    logic [WIDTH-1:0] y;
    logic [EW-1:0]    wide;

    assign ymode = yin_e'(ysel);

    always_comb begin
        unique case (ymode)
            Y_B:    y = b;
            Y_NOTB: y = ~b;
            Y_ZERO: y = '0;
            Y_ONES: y = '1;
            default: y = '0;
        endcase
    end

    assign wide  = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    assign sum   = wide[WIDTH-1:0];
    assign carry = wide[WIDTH];

    always_comb begin
        if (ymode == Y_ZERO && !cin) begin
            p_transfer_r3: assert (sum == a && !carry)
                else $error("adder transfer does not reproduce a");
        end
        if (ymode == Y_ONES && cin) begin
            p_dec_transfer_r4: assert (sum == a && carry)
                else $error("all-ones plus carry does not reproduce a");
        end
    end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fsel,
    output logic [WIDTH-1:0] res
);
    lfn_e fn;
    assign fn = lfn_e'(fsel);

    always_comb begin
        unique case (fn)
            L_AND:  res = a & b;
            L_OR:   res = a | b;
            L_XOR:  res = a ^ b;
            L_NOTA: res = ~a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             to_left,
    input  logic             fill_r,
    input  logic             fill_l,
    output logic [WIDTH-1:0] res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_src;
        logic dn_src;
        if (i == 0) begin : g_lsb
            assign up_src = fill_l;
        end else begin : g_lo
            assign up_src = a[i-1];
        end
        if (i == WIDTH - 1) begin : g_msb
            assign dn_src = fill_r;
        end else begin : g_hi
            assign dn_src = a[i+1];
        end
        assign res[i] = to_left ? up_src : dn_src;
    end

endmodule

// File: rtl/alsu_top.sv
module alsu_top
    import alsu_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       sel,
    input  logic             cin,
    input  logic             ser_right,
    input  logic             ser_left,
    output logic [WIDTH-1:0] f,
    output logic             cout
);
    unit_e            unit;
    logic [WIDTH-1:0] arith_f;
    logic             arith_c;
    logic [WIDTH-1:0] logic_f;
    logic [WIDTH-1:0] shift_f;
    logic [WIDTH-1:0] f_c;
    logic             cout_c;

    assign unit = unit_e'(sel[3:2]);

    alsu_arith #(.WIDTH(WIDTH)) u_arith (
        .a     (a),
        .b     (b),
        .ysel  (sel[1:0]),
        .cin   (cin),
        .sum   (arith_f),
        .carry (arith_c)
    );

    alsu_logic #(.WIDTH(WIDTH)) u_logic (
        .a    (a),
        .b    (b),
        .fsel (sel[1:0]),
        .res  (logic_f)
    );

    alsu_shift #(.WIDTH(WIDTH)) u_shift (
        .a       (a),
        .to_left (sel[2]),
        .fill_r  (ser_right),
        .fill_l  (ser_left),
        .res     (shift_f)
    );

    always_comb begin
        unique case (unit)
            U_ARITH: begin
                f_c    = arith_f;
                cout_c = arith_c;
            end
            U_LOGIC: begin
                f_c    = logic_f;
                cout_c = 1'b0;
            end
            U_SHR, U_SHL: begin
                f_c    = shift_f;
                cout_c = 1'b0;
            end
            default: begin
                f_c    = '0;
                cout_c = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (unit != U_ARITH) begin
            p_no_carry_r8: assert (!cout_c)
                else $error("carry leaks out of a non-adder operation");
        end
        if (unit == U_SHR) begin
            p_shr_fill_r6: assert (f_c[WIDTH-1] == ser_right && f_c[WIDTH-2:0] == a[WIDTH-1:1])
                else $error("right shift result wrong");
        end
        if (unit == U_SHL) begin
            p_shl_fill_r7: assert (f_c[0] == ser_left && f_c[WIDTH-1:1] == a[WIDTH-2:0])
                else $error("left shift result wrong");
        end
        if (unit == U_LOGIC && sel[1:0] == 2'b11) begin
            p_not_a_r5: assert (f_c == ~a)
                else $error("complement of a wrong");
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                f    <= '0;
                cout <= 1'b0;
            end else begin
                f    <= f_c;
                cout <= cout_c;
            end
        end
    end else begin : g_comb
        assign f    = f_c;
        assign cout = cout_c;
    end

endmodule

// File: tb/tb_alsu_top.sv
module tb_alsu_top;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   sel = '0;
    logic         cin = 1'b0;
    logic         ser_right = 1'b0;
    logic         ser_left = 1'b0;
    logic [W-1:0] f;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alsu_top #(.WIDTH(W), .OUT_REG(1'b1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a         (a),
        .b         (b),
        .sel       (sel),
        .cin       (cin),
        .ser_right (ser_right),
        .ser_left  (ser_left),
        .f         (f),
        .cout      (cout)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (a=%0d b=%0d sel=%b cin=%0d)",
                     req, what, act, exp, a, b, sel, cin);
        end
    endtask

    initial begin
        a = 4'hF; b = 4'hF; sel = 4'b0000; cin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "reset f", int'(f), 0);
        chk("R9", "reset cout", int'(cout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: registered one clock after the edge, 15+15+1 = 31
        chk("R9", "latency f", int'(f), 31 & MASK);
        chk("R9", "latency cout", int'(cout), 1);

        for (int s = 0; s < 16; s++) begin
            for (int ai = 0; ai <= MASK; ai++) begin
                for (int bi = 0; bi <= MASK; bi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        for (int sv = 0; sv < 4; sv++) begin
                            int    yv;
                            int    tot;
                            int    ef;
                            int    ec;
                            string rq;
                            a = W'(ai); b = W'(bi); sel = 4'(s); cin = ci[0];
                            ser_right = sv[0]; ser_left = sv[1];
                            ec = 0;
                            case (s >> 2)
                                0: begin
                                    case (s & 3)
                                        0: begin yv = bi;          rq = "R1"; end
                                        1: begin yv = MASK - bi;   rq = "R2"; end
                                        2: begin yv = 0;           rq = "R3"; end
                                        default: begin yv = MASK;  rq = "R4"; end
                                    endcase
                                    tot = ai + yv + ci;
                                    ef  = tot & MASK;
                                    ec  = tot >> W;
                                end
                                1: begin
                                    rq = "R5";
                                    case (s & 3)
                                        0: ef = ai & bi;
                                        1: ef = ai | bi;
                                        2: ef = ai ^ bi;
                                        default: ef = MASK - ai;
                                    endcase
                                end
                                2: begin
                                    rq = "R6";
                                    ef = ((sv & 1) << (W - 1)) | (ai >> 1);
                                end
                                default: begin
                                    rq = "R7";
                                    ef = ((ai << 1) | (sv >> 1)) & MASK;
                                end
                            endcase
                            @(negedge clk);
                            chk(rq, "f", int'(f), ef);
                            chk(((s >> 2) == 0) ? rq : "R8", "cout", int'(cout), ec);
                        end
                    end
                end
            end
        end

        // R9: reset asserted mid-run clears outputs without a clock edge
        sel = 4'b0111; a = 4'h0;
        @(negedge clk);
        chk("R9", "pre-reset f", int'(f), MASK);
        rst_n = 1'b0;
        #1;
        chk("R9", "async reset f", int'(f), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule